// File: doc/BRIEF.md
# Streaming Sample Statistics Unit

This unit watches a stream of unsigned samples, each qualified by a valid strobe, and keeps four running results over every sample accepted since the last clear. These are the smallest sample, the largest sample, their total, and how many samples there were. Downstream logic or software divides the total by the tally to get the mean. The unit does no division itself.

The minimum, maximum and total trackers can each be removed at elaboration time through their own enable parameter. A removed tracker builds no registers and drives a constant zero on its output. The total register is wider than a sample by a configurable number of guard bits, 16 by default. Both the total and the tally stop at all-ones instead of wrapping. A synchronous clear returns every tracker to its empty state.

Top module: `stat_accum`

## Requirements
- R1: After the asynchronous active-low reset, `min_o` is all-ones, `max_o` is zero, `sum_o` is zero and `cnt_o` is zero.
- R2: On each clock edge with `smp_vld_i`=1 and `clr_i`=0, `min_o` becomes the unsigned minimum of its previous value and `smp_val_i`.
- R3: On each clock edge with `smp_vld_i`=1 and `clr_i`=0, `max_o` becomes the unsigned maximum of its previous value and `smp_val_i`.
- R4: On each accepted sample, `sum_o` (VAL_W+GUARD_W bits wide) adds the zero-extended sample. A total that would exceed all-ones is held at all-ones.
- R5: On each accepted sample, `cnt_o` (CNT_W bits) increases by one. At all-ones it stays at all-ones.
- R6: A clock edge with `clr_i`=1 restores the reset values of R1. A sample presented in the same cycle is discarded.
- R7: A clock edge with `smp_vld_i`=0 and `clr_i`=0 leaves all four outputs unchanged, whatever `smp_val_i` is.
- R8: When MIN_ON, MAX_ON or SUM_ON is 0, the matching output is constant zero. The other outputs, including `cnt_o`, behave as above.
- R9: All outputs are registered. A sample accepted at a clock edge is reflected on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous return to the empty state |
| smp_vld_i | input | 1 | Sample qualifier |
| smp_val_i | input | VAL_W | Unsigned sample |
| min_o | output | VAL_W | Smallest sample since clear |
| max_o | output | VAL_W | Largest sample since clear |
| sum_o | output | VAL_W+GUARD_W | Saturating total of samples |
| cnt_o | output | CNT_W | Saturating number of samples |

## Verification
On every cycle, the assertions check several ordering properties. The minimum never rises and the maximum never falls between clears. The total never shrinks. The tally steps by exactly one per sample below saturation and holds still on idle cycles. A clear empties every tracker on the next cycle. The exact values can only be shown by the bench's scenarios, which run the bench model on every clock: the order in which extremes are replaced, the point where the total and the tally saturate, the zero/all-ones boundary samples, a clear colliding with a sample, and a second instance with the trackers removed.

// File: rtl/stat_pkg.sv
package stat_pkg;
   typedef enum logic {EXT_MIN = 1'b0, EXT_MAX = 1'b1} ext_kind_e;
endpackage

// File: rtl/stat_extreme.sv
module stat_extreme
   import stat_pkg::*;
#(
   parameter int        W    = 16,
   parameter ext_kind_e KIND = EXT_MIN
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         vld,
   input  logic [W-1:0] val,
   output logic [W-1:0] ext
);
   localparam logic [W-1:0] EMPTY = (KIND == EXT_MIN) ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] ext_q;
   logic         take;

   // replace when the new sample is strictly beyond the held extreme
   always_comb begin
      if (KIND == EXT_MIN) take = val < ext_q;
      else                 take = val > ext_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ext_q <= EMPTY;
      else if (clr)           ext_q <= EMPTY;
      else if (vld && take)   ext_q <= val;
   end

   assign ext = ext_q;
endmodule

// File: rtl/stat_sat_acc.sv
module stat_sat_acc #(
   parameter int W    = 32,
   parameter int IN_W = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            vld,
   input  logic [IN_W-1:0] inc,
   output logic [W-1:0]    acc
);
   localparam int EXT_W = W + 1;

   logic [W-1:0]     acc_q;
   logic [EXT_W-1:0] nxt;

   initial begin
      if (IN_W > W) $error("stat_sat_acc: increment wider than accumulator");
   end

   assign nxt = {1'b0, acc_q} + EXT_W'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr)   acc_q <= '0;
      else if (vld)   acc_q <= nxt[W] ? {W{1'b1}} : nxt[W-1:0];
   end

   assign acc = acc_q;
endmodule

// File: rtl/stat_accum.sv
module stat_accum
   import stat_pkg::*;
#(
   parameter int VAL_W   = 16,
   parameter int GUARD_W = 16,
   parameter int CNT_W   = 32,
   parameter bit MIN_ON  = 1'b1,
   parameter bit MAX_ON  = 1'b1,
   parameter bit SUM_ON  = 1'b1,
   localparam int SUM_W  = VAL_W + GUARD_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             smp_vld_i,
   input  logic [VAL_W-1:0] smp_val_i,
   output logic [VAL_W-1:0] min_o,
   output logic [VAL_W-1:0] max_o,
   output logic [SUM_W-1:0] sum_o,
   output logic [CNT_W-1:0] cnt_o
);
   if (VAL_W < 1)   $error("stat_accum: VAL_W must be at least 1");
   if (GUARD_W < 0) $error("stat_accum: GUARD_W must not be negative");
   if (CNT_W < 1)   $error("stat_accum: CNT_W must be at least 1");

   if (MIN_ON) begin : g_min
      stat_extreme #(.W(VAL_W), .KIND(EXT_MIN)) u_min (
         .clk(clk), .rst_n(rst_n), .clr(clr_i), .vld(smp_vld_i),
         .val(smp_val_i), .ext(min_o));
   end else begin : g_nomin
      assign min_o = '0;
   end

   if (MAX_ON) begin : g_max
      stat_extreme #(.W(VAL_W), .KIND(EXT_MAX)) u_max (
         .clk(clk), .rst_n(rst_n), .clr(clr_i), .vld(smp_vld_i),
         .val(smp_val_i), .ext(max_o));
   end else begin : g_nomax
      assign max_o = '0;
   end

   if (SUM_ON) begin : g_sum
      stat_sat_acc #(.W(SUM_W), .IN_W(VAL_W)) u_sum (
         .clk(clk), .rst_n(rst_n), .clr(clr_i), .vld(smp_vld_i),
         .inc(smp_val_i), .acc(sum_o));
   end else begin : g_nosum
      assign sum_o = '0;
   end

   // the tally is always present: it is the divisor for the mean
   stat_sat_acc #(.W(CNT_W), .IN_W(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_i), .vld(smp_vld_i),
      .inc(1'b1), .acc(cnt_o));
endmodule

// File: rtl/stat_accum_chk.sv
module stat_accum_chk #(
   parameter int VAL_W   = 16,
   parameter int GUARD_W = 16,
   parameter int CNT_W   = 32,
   parameter bit MIN_ON  = 1'b1,
   parameter bit MAX_ON  = 1'b1,
   parameter bit SUM_ON  = 1'b1,
   localparam int SUM_W  = VAL_W + GUARD_W
)(
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic             smp_vld_i,
   input logic [VAL_W-1:0] smp_val_i,
   input logic [VAL_W-1:0] min_o,
   input logic [VAL_W-1:0] max_o,
   input logic [SUM_W-1:0] sum_o,
   input logic [CNT_W-1:0] cnt_o
);
   assert_min_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> min_o <= $past(min_o));

   assert_max_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> max_o >= $past(max_o));

   assert_sum_no_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> sum_o >= $past(sum_o));

   assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && smp_vld_i && cnt_o != {CNT_W{1'b1}}) |=> cnt_o == $past(cnt_o) + 1'b1);

   assert_clear_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0 && sum_o == '0 && max_o == '0));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !smp_vld_i) |=> ($stable(cnt_o) && $stable(sum_o) && $stable(min_o) && $stable(max_o)));

   if (MIN_ON) begin : g_minchk
      assert_min_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && smp_vld_i) |=> min_o <= $past(smp_val_i));
   end
   if (MAX_ON) begin : g_maxchk
      assert_max_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && smp_vld_i) |=> max_o >= $past(smp_val_i));
   end
endmodule

bind stat_accum stat_accum_chk #(
   .VAL_W(VAL_W), .GUARD_W(GUARD_W), .CNT_W(CNT_W),
   .MIN_ON(MIN_ON), .MAX_ON(MAX_ON), .SUM_ON(SUM_ON)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .smp_vld_i(smp_vld_i),
   .smp_val_i(smp_val_i), .min_o(min_o), .max_o(max_o),
   .sum_o(sum_o), .cnt_o(cnt_o));

// File: tb/sim_stat_accum.sv
module sim_stat_accum;
   localparam int VW = 8, GW = 2, CW = 4, SW = VW + GW;
   localparam int VMAX = (1 << VW) - 1, SMAX = (1 << SW) - 1, CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0;
   logic [VW-1:0] val = '0;
   logic [VW-1:0] mn0, mx0, mn1, mx1;
   logic [SW-1:0] sm0, sm1;
   logic [CW-1:0] ct0, ct1;

   int total = 0, bad = 0, cyc = 0;
   int m_mn = VMAX, m_mx = 0, m_sm = 0, m_ct = 0;
   bit done = 0;

   always #2 clk = ~clk;

   stat_accum #(.VAL_W(VW), .GUARD_W(GW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .smp_vld_i(vld), .smp_val_i(val),
      .min_o(mn0), .max_o(mx0), .sum_o(sm0), .cnt_o(ct0));

   stat_accum #(.VAL_W(VW), .GUARD_W(GW), .CNT_W(CW),
                .MIN_ON(1'b0), .MAX_ON(1'b0), .SUM_ON(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .smp_vld_i(vld), .smp_val_i(val),
      .min_o(mn1), .max_o(mx1), .sum_o(sm1), .cnt_o(ct1));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model (R6 clear wins, R4/R5 saturate)
   always @(posedge clk) begin
      cyc++;
      if (!rst_n || clr) begin
         m_mn = VMAX; m_mx = 0; m_sm = 0; m_ct = 0;
      end else if (vld) begin
         if (val < m_mn) m_mn = val;
         if (val > m_mx) m_mx = val;
         m_sm = (m_sm + val > SMAX) ? SMAX : m_sm + val;
         m_ct = (m_ct == CMAX) ? CMAX : m_ct + 1;
      end
   end

   // every-clock comparison (R9: results visible right after the edge)
   always @(negedge clk) if (rst_n && !done) begin
      chk("R2 min", mn0, m_mn);
      chk("R3 max", mx0, m_mx);
      chk("R4 sum", sm0, m_sm);
      chk("R5 cnt", ct0, m_ct);
      chk("R8 min off", mn1, 0);
      chk("R8 max off", mx1, 0);
      chk("R8 sum off", sm1, 0);
      chk("R8 cnt kept", ct1, m_ct);
   end

   task automatic step(input bit v, input int x, input bit c);
      @(posedge clk); #1;
      vld = v; val = VW'(x); clr = c;
      @(posedge clk); #1;
      vld = 1'b0; clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 min", mn0, VMAX); chk("R1 max", mx0, 0);
      chk("R1 sum", sm0, 0);    chk("R1 cnt", ct0, 0);
      rst_n = 1'b1;
      step(1, 50, 0);
      @(negedge clk); chk("R9 min", mn0, 50); chk("R9 max", mx0, 50);
      step(1, 200, 0); step(1, 10, 0); step(1, 120, 0);
      @(negedge clk);
      chk("R2", mn0, 10); chk("R3", mx0, 200); chk("R4", sm0, 380); chk("R5", ct0, 4);
      step(0, 0, 0); step(0, 255, 0); step(0, 3, 0);
      @(negedge clk);
      chk("R7 min", mn0, 10); chk("R7 max", mx0, 200);
      chk("R7 sum", sm0, 380); chk("R7 cnt", ct0, 4);
      step(1, 77, 1);
      @(negedge clk);
      chk("R6 min", mn0, VMAX); chk("R6 max", mx0, 0);
      chk("R6 sum", sm0, 0);    chk("R6 cnt", ct0, 0);
      step(1, 0, 0); step(1, 255, 0);
      @(negedge clk); chk("R2 zero", mn0, 0); chk("R3 top", mx0, 255);
      for (int i = 0; i < 6; i++) step(1, 255, 0);
      @(negedge clk); chk("R4 sat", sm0, SMAX);
      for (int i = 0; i < 10; i++) step(1, i, 0);
      @(negedge clk); chk("R5 sat", ct0, CMAX); chk("R4 held", sm0, SMAX);
      step(0, 0, 1);
      @(negedge clk); chk("R6 again", ct0, 0);
      step(1, 9, 0);
      @(negedge clk); chk("R8 cnt", ct1, 1); chk("R8 min", mn1, 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule